// File: doc/BRIEF.md
# Per-Packet Antenna Selection Controller

This block picks one of two RF antenna paths for every packet and holds that pick until the packet is over. For transmission the antenna always comes from a software-written configuration bit. For reception the controller works in one of two modes. In automatic mode it compares the gain codes the automatic gain control settled on for each path when the packet began, and treats the path that needed less gain as the stronger one. In forced mode software names the receive antenna directly.

The receive configuration is copied into a shadow copy while no packet is in flight. The decision is made on the gain-control done strobe and frozen until the packet-end strobe. The transmit configuration is copied only while transmission is inactive. A single select line drives the RF switch: it follows the transmit copy while transmission is active and the last receive decision otherwise. A small status word reports the last receive decision.

Top module: `ant_sel_ctrl`

## Requirements
- R1: After reset `ant_sel_o` is 0 and `status_o` is 3'b000.
- R2: While `tx_active_i` is high, `ant_sel_o` equals the value `cfg_tx_ant_i` had on the last clock edge at which `tx_active_i` was low. Changes to `cfg_tx_ant_i` while `tx_active_i` is high have no effect on `ant_sel_o`.
- R3: In automatic mode the decision is the path with the lower total gain, where total = coarse code + fine code, summed without loss of carry. Path 0 uses bits [RF_W-1:0] of `agc_rf_gain_i` and [BB_W-1:0] of `agc_bb_gain_i`. Path 1 uses the next field of each bus.
- R4: In automatic mode, equal totals select antenna 0.
- R5: In forced mode (`cfg_rx_force_i` = 1 when captured) the decision is the captured `cfg_rx_ant_i`, whatever the gain codes are.
- R6: A decision is taken only on the first `agc_done_i` after `pkt_start_i`. It takes effect on the edge that samples the strobe and is held until a later packet decides again. Further `agc_done_i` pulses in the same packet are ignored.
- R7: The receive mode and forced antenna are captured at the edge that samples `pkt_start_i`. Changes made before `pkt_end_i` are ignored for that packet and apply from the next packet.
- R8: `status_o` is {valid, forced, antenna} at bits [2], [1], [0]. It is updated on the same edge as the decision, and valid is set by the first decision.
- R9: An `agc_done_i` outside a packet is ignored. A packet ended by `pkt_end_i` before any `agc_done_i` makes no decision and leaves `status_o` unchanged.
- R10: While `tx_active_i` is low, `ant_sel_o` equals the last receive decision, which is 0 before any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_tx_ant_i | input | 1 | Software transmit antenna |
| cfg_rx_force_i | input | 1 | Software receive override enable |
| cfg_rx_ant_i | input | 1 | Software forced receive antenna |
| agc_rf_gain_i | input | 2*RF_W | Coarse gain codes, path 0 in low field |
| agc_bb_gain_i | input | 2*BB_W | Fine gain codes, path 0 in low field |
| agc_done_i | input | 1 | Gain control settled strobe |
| pkt_start_i | input | 1 | Receive packet start strobe |
| pkt_end_i | input | 1 | Receive packet end strobe |
| tx_active_i | input | 1 | Transmission in progress |
| ant_sel_o | output | 1 | Antenna switch select |
| status_o | output | 3 | {valid, forced, antenna} of last receive decision |

## Verification
The bench builds the block with RF_W = 2 and BB_W = 5. With these widths a path total can reach 34, which does not fit in the 5-bit width of the wider field. A vector whose totals compare one way only when the carry is kept therefore exposes a truncated adder. The narrow coarse field also makes it cheap to build exact ties from different coarse and fine splits, and to build forced decisions that go against the gain comparison.

// File: rtl/ant_sel_pkg.sv
package ant_sel_pkg;

  localparam int unsigned NUM_PATHS = 2;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_AGC = 2'd1,
    ST_HOLD     = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic valid;
    logic forced;
    logic ant;
  } ant_status_t;

  localparam int unsigned STATUS_W = $bits(ant_status_t);

endpackage

// File: rtl/ant_gain_cmp.sv
module ant_gain_cmp
  import ant_sel_pkg::*;
#(
  parameter int unsigned RF_W = 2,
  parameter int unsigned BB_W = 5
) (
  input  logic [NUM_PATHS*RF_W-1:0] rf_gain_i,
  input  logic [NUM_PATHS*BB_W-1:0] bb_gain_i,
  output logic                      pick_o
);

  localparam int unsigned MAX_W = (RF_W > BB_W) ? RF_W : BB_W;
  localparam int unsigned SUM_W = MAX_W + 1;

  logic [SUM_W-1:0] total [NUM_PATHS];

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    assign total[g] = SUM_W'(rf_gain_i[g*RF_W +: RF_W])
                    + SUM_W'(bb_gain_i[g*BB_W +: BB_W]);
  end

  // lower total gain = stronger path; tie keeps path 0
  assign pick_o = (total[1] < total[0]);

endmodule

// File: rtl/ant_cfg_shadow.sv
module ant_cfg_shadow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_tx_ant_i,
  input  logic cfg_rx_force_i,
  input  logic cfg_rx_ant_i,
  input  logic tx_active_i,
  input  logic rx_busy_i,
  output logic tx_ant_o,
  output logic rx_force_o,
  output logic rx_ant_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ant_o <= 1'b0;
    end else if (!tx_active_i) begin
      tx_ant_o <= cfg_tx_ant_i;
    end
  end

  // receive copy tracks software only between packets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_force_o <= 1'b0;
      rx_ant_o   <= 1'b0;
    end else if (!rx_busy_i) begin
      rx_force_o <= cfg_rx_force_i;
      rx_ant_o   <= cfg_rx_ant_i;
    end
  end

  p_tx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> $stable(tx_ant_o));

  p_rx_cfg_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy_i |=> ($stable(rx_force_o) && $stable(rx_ant_o)));

endmodule

// File: rtl/ant_rx_fsm.sv
module ant_rx_fsm
  import ant_sel_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pkt_start_i,
  input  logic        pkt_end_i,
  input  logic        agc_done_i,
  input  logic        force_i,
  input  logic        force_ant_i,
  input  logic        pick_i,
  output logic        busy_o,
  output logic        rx_ant_o,
  output ant_status_t status_o
);

  rx_state_e state_q, state_d;
  logic      decide;
  logic      choice;

  assign decide = (state_q == ST_WAIT_AGC) && agc_done_i && !pkt_end_i;
  assign choice = force_i ? force_ant_i : pick_i;
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (pkt_start_i) state_d = ST_WAIT_AGC;
      ST_WAIT_AGC: if (pkt_end_i) state_d = ST_IDLE;
                   else if (agc_done_i) state_d = ST_HOLD;
      ST_HOLD:     if (pkt_end_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rx_ant_o <= 1'b0;
      status_o <= '0;
    end else begin
      state_q <= state_d;
      if (decide) begin
        rx_ant_o <= choice;
        status_o <= '{valid: 1'b1, forced: force_i, ant: choice};
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WAIT_AGC) |=> $stable(rx_ant_o));

  p_forced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && force_i) |=> (rx_ant_o == $past(force_ant_i)));

  p_auto_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && !force_i) |=> (rx_ant_o == $past(pick_i)));

  p_status_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o.valid) |-> $past(decide));

  p_no_decide_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> $stable(status_o));

endmodule

// File: rtl/ant_sel_ctrl.sv
module ant_sel_ctrl
  import ant_sel_pkg::*;
#(
  parameter int unsigned RF_W = 2,
  parameter int unsigned BB_W = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_tx_ant_i,
  input  logic                      cfg_rx_force_i,
  input  logic                      cfg_rx_ant_i,
  input  logic [NUM_PATHS*RF_W-1:0] agc_rf_gain_i,
  input  logic [NUM_PATHS*BB_W-1:0] agc_bb_gain_i,
  input  logic                      agc_done_i,
  input  logic                      pkt_start_i,
  input  logic                      pkt_end_i,
  input  logic                      tx_active_i,
  output logic                      ant_sel_o,
  output logic [STATUS_W-1:0]       status_o
);

  logic        pick;
  logic        rx_busy;
  logic        tx_ant_sh, rx_force_sh, rx_ant_sh;
  logic        rx_ant;
  ant_status_t status;

  ant_gain_cmp #(.RF_W(RF_W), .BB_W(BB_W)) u_cmp (
    .rf_gain_i (agc_rf_gain_i),
    .bb_gain_i (agc_bb_gain_i),
    .pick_o    (pick)
  );

  ant_cfg_shadow u_shadow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_tx_ant_i   (cfg_tx_ant_i),
    .cfg_rx_force_i (cfg_rx_force_i),
    .cfg_rx_ant_i   (cfg_rx_ant_i),
    .tx_active_i    (tx_active_i),
    .rx_busy_i      (rx_busy),
    .tx_ant_o       (tx_ant_sh),
    .rx_force_o     (rx_force_sh),
    .rx_ant_o       (rx_ant_sh)
  );

  ant_rx_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_start_i (pkt_start_i),
    .pkt_end_i   (pkt_end_i),
    .agc_done_i  (agc_done_i),
    .force_i     (rx_force_sh),
    .force_ant_i (rx_ant_sh),
    .pick_i      (pick),
    .busy_o      (rx_busy),
    .rx_ant_o    (rx_ant),
    .status_o    (status)
  );

  assign ant_sel_o = tx_active_i ? tx_ant_sh : rx_ant;
  assign status_o  = status;

  p_rx_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |-> (ant_sel_o == status_o[0]));

  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (status_o == '0));

endmodule

// File: tb/tb_ant_sel_ctrl.sv
`timescale 1ns/1ps
module tb_ant_sel_ctrl;

  localparam int RF_W = 2;
  localparam int BB_W = 5;
  localparam int NV   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_tx = 1'b0, cfg_force = 1'b0, cfg_ant = 1'b0;
  logic [2*RF_W-1:0] rf = '0;
  logic [2*BB_W-1:0] bb = '0;
  logic            agc_done = 1'b0, pkt_start = 1'b0, pkt_end = 1'b0, tx_act = 1'b0;
  logic            sel;
  logic [2:0]      status;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ant_sel_ctrl #(.RF_W(RF_W), .BB_W(BB_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_tx_ant_i(cfg_tx), .cfg_rx_force_i(cfg_force), .cfg_rx_ant_i(cfg_ant),
    .agc_rf_gain_i(rf), .agc_bb_gain_i(bb), .agc_done_i(agc_done),
    .pkt_start_i(pkt_start), .pkt_end_i(pkt_end), .tx_active_i(tx_act),
    .ant_sel_o(sel), .status_o(status)
  );

  // {force, ant, rf0, bb0, rf1, bb1, expected antenna}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd1, 5'd10, 2'd0, 5'd20, 1'b0},  // R3 path 0 lower
    {1'b0, 1'b0, 2'd2, 5'd20, 2'd1, 5'd5,  1'b1},  // R3 path 1 lower
    {1'b0, 1'b0, 2'd1, 5'd4,  2'd2, 5'd3,  1'b0},  // R4 tie
    {1'b0, 1'b0, 2'd3, 5'd31, 2'd0, 5'd30, 1'b1},  // R3 carry kept: 34 vs 30
    {1'b1, 1'b1, 2'd0, 5'd0,  2'd3, 5'd31, 1'b1},  // R5 forced 1 against gains
    {1'b1, 1'b0, 2'd3, 5'd31, 2'd0, 5'd0,  1'b0},  // R5 forced 0 against gains
    {1'b0, 1'b1, 2'd0, 5'd0,  2'd0, 5'd1,  1'b0},  // R3 ant bit ignored in auto
    {1'b0, 1'b0, 2'd0, 5'd1,  2'd0, 5'd0,  1'b1}   // R3
  };

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_gains(logic [1:0] r0, logic [4:0] b0, logic [1:0] r1, logic [4:0] b1);
    rf = {r1, r0};
    bb = {b1, b0};
  endtask

  task automatic start_decide(logic f, logic a, logic [1:0] r0, logic [4:0] b0,
                              logic [1:0] r1, logic [4:0] b1);
    @(negedge clk); cfg_force = f; cfg_ant = a; pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0; agc_done = 1'b1; set_gains(r0, b0, r1, b1);
    @(negedge clk); agc_done = 1'b0;
  endtask

  task automatic end_pkt();
    @(negedge clk); pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 3'b000);
    chk("R1 sel", {2'b0, sel}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel after release", {2'b0, sel}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      start_decide(v[16], v[15], v[14:13], v[12:8], v[7:6], v[5:1]);
      chk("R3/R4/R5/R8 status", status, {1'b1, v[16], v[0]});
      chk("R10 sel", {2'b0, sel}, {2'b0, v[0]});
      end_pkt();
    end

    // R7: mid-packet override ignored, applies next packet
    @(negedge clk); cfg_force = 1'b0; cfg_ant = 1'b0; pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0; cfg_force = 1'b1; cfg_ant = 1'b1;
    @(negedge clk); agc_done = 1'b1; set_gains(2'd0, 5'd0, 2'd3, 5'd31);
    @(negedge clk); agc_done = 1'b0;
    chk("R7 mid-packet cfg ignored", status, 3'b100);
    end_pkt();
    start_decide(1'b1, 1'b1, 2'd0, 5'd0, 2'd3, 5'd31);
    chk("R7 cfg applied next packet", status, 3'b111);
    end_pkt();

    // R6: second done in same packet ignored
    start_decide(1'b0, 1'b0, 2'd0, 5'd0, 2'd3, 5'd31);
    chk("R6 first decision", status, 3'b100);
    @(negedge clk); agc_done = 1'b1; set_gains(2'd3, 5'd31, 2'd0, 5'd0);
    @(negedge clk); agc_done = 1'b0;
    @(negedge clk);
    chk("R6 second done ignored", status, 3'b100);
    chk("R6 sel held", {2'b0, sel}, 3'b000);
    end_pkt();

    // R9: done while idle, and packet ended before done
    @(negedge clk); agc_done = 1'b1; set_gains(2'd3, 5'd31, 2'd0, 5'd0);
    @(negedge clk); agc_done = 1'b0;
    chk("R9 idle done ignored", status, 3'b100);
    @(negedge clk); pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0; pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0; agc_done = 1'b1;
    @(negedge clk); agc_done = 1'b0;
    chk("R9 aborted packet no decision", status, 3'b100);
    chk("R9 sel unchanged", {2'b0, sel}, 3'b000);

    // R2 / R10: transmit path
    @(negedge clk); cfg_tx = 1'b1;
    @(negedge clk); tx_act = 1'b1;
    #1;
    chk("R2 tx sel", {2'b0, sel}, 3'b001);
    @(negedge clk); cfg_tx = 1'b0;
    @(negedge clk);
    chk("R2 tx cfg change ignored", {2'b0, sel}, 3'b001);
    tx_act = 1'b0;
    #1;
    chk("R10 back to rx decision", {2'b0, sel}, 3'b000);
    @(negedge clk); tx_act = 1'b1;
    #1;
    chk("R2 new tx capture", {2'b0, sel}, 3'b000);
    @(negedge clk); tx_act = 1'b0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule